// File: doc/BRIEF.md
# Collision Vector Generator

This block computes the collision vector of a single pipeline function from its reservation table. The table is given as one row mask per stage. Each mask has one bit per clock column, and a set bit means that stage is busy in that column. Two initiations separated by a latency of i cycles collide when some stage is busy in two columns exactly i apart. The block tests every latency from 1 to COLS-1 and sets one vector bit for each latency that collides.

The work is sequential. A start pulse captures the table and clears the previous result. The block then tests one latency per clock cycle, in increasing order. When the largest latency has been tested it raises a one-cycle done pulse. The finished vector and the maximum forbidden latency stay on the outputs until the next start. A pipeline scheduler or a design-time configuration step can read them from there, for example to decide which latencies are legal when it issues new operations.

Top module: `collision_vector_gen`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `done`, `cvec` and `max_lat` are all zero.
- R2: Bit k of stage row s (`table_rows[s*COLS+k]`) marks column k+1. When `done` is high, bit i-1 of `cvec` is 1 exactly when some row has set bits in two columns i apart, for every latency i in 1..COLS-1. Read from its top bit down, the vector runs from latency COLS-1 to latency 1.
- R3: When `done` is high, `max_lat` equals the largest forbidden latency, and it is 0 when no latency is forbidden. No `cvec` bit above bit `max_lat`-1 is set.
- R4: `done` is high for exactly one cycle. That cycle follows the COLS-1'th rising edge after the edge that samples `start`. `busy` is high from the edge that samples `start` until `done` rises.
- R5: In the cycle after `start` is sampled, `cvec` and `max_lat` read zero and `busy` is high.
- R6: The table is captured when `start` is sampled. Changes on `table_rows` while `busy` is high have no effect on the result.
- R7: A `start` sampled while `busy` is high restarts the run with the new table. The `done` pulse then comes COLS-1 edges after the new start and carries only the new table's result.
- R8: While idle and without `start`, `cvec` and `max_lat` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run: capture the table and clear the result |
| table_rows | input | STAGES*COLS | Reservation table, row s in bits [s*COLS +: COLS], bit k = column k+1 |
| busy | output | 1 | Latency tests in progress |
| done | output | 1 | One-cycle pulse when all latencies have been tested |
| cvec | output | COLS-1 | Collision vector, bit i-1 set when latency i is forbidden |
| max_lat | output | $clog2(COLS) | Largest forbidden latency, 0 if none |

## Verification
The bench builds the block with STAGES=3 and COLS=8. With these values a three-stage, eight-column table is in reach, whose forbidden latencies are 2, 4, 5 and 7 (vector 1011010). Eight columns also reach the extremes: a fully occupied row that forbids every latency, single checkmarks that forbid none, and a row whose only collision lies at the largest latency, 7. The vector table walks these patterns, and directed tests cover mid-run table changes, a restart while busy and a reset during a run.

// File: rtl/collision_vector_gen.sv
module collision_vector_gen #(
  parameter int STAGES = 4,
  parameter int COLS   = 8,
  localparam int LAT_W = $clog2(COLS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [STAGES*COLS-1:0]   table_rows,
  output logic                     busy,
  output logic                     done,
  output logic [COLS-2:0]          cvec,
  output logic [LAT_W-1:0]         max_lat
);

  localparam logic [LAT_W-1:0] LAST_LAT = LAT_W'(COLS - 1);

  logic [STAGES*COLS-1:0] tbl_q;
  logic [LAT_W-1:0]       lat;
  logic [STAGES-1:0]      row_hit;
  logic                   hit;

  for (genvar s = 0; s < STAGES; s++) begin : g_row
    logic [COLS-1:0] row;
    assign row        = tbl_q[s*COLS +: COLS];
    assign row_hit[s] = |(row & (row >> lat));
  end

  assign hit = |row_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_q   <= '0;
      lat     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      cvec    <= '0;
      max_lat <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        tbl_q   <= table_rows;
        lat     <= LAT_W'(1);
        busy    <= 1'b1;
        cvec    <= '0;
        max_lat <= '0;
      end else if (busy) begin
        if (hit) begin
          cvec[lat - LAT_W'(1)] <= 1'b1;
          max_lat               <= lat;
        end
        if (lat == LAST_LAT) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          lat <= lat + LAT_W'(1);
        end
      end
    end
  end

  // R2: only latencies 1..COLS-1 are ever tested
  p_lat_range_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (lat >= LAT_W'(1)) && (lat <= LAST_LAT));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_ends_busy_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));

  p_start_clears_r5: assert property (@(posedge clk) disable iff (rst)
    start |=> busy && (cvec == '0) && (max_lat == '0));

  p_max_zero_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> ((max_lat == '0) == (cvec == '0)));

  p_max_top_r3: assert property (@(posedge clk) disable iff (rst)
    (done && max_lat != '0) |-> cvec[max_lat - LAT_W'(1)] && ((cvec >> max_lat) == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(cvec) && $stable(max_lat));

endmodule

// File: tb/tb_collision_vector_gen.sv
module tb_collision_vector_gen;
  localparam int STAGES = 3;
  localparam int COLS   = 8;
  localparam int TW     = STAGES * COLS;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [TW-1:0] table_rows;
  logic          busy, done;
  logic [6:0]    cvec;
  logic [2:0]    max_lat;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #5 clk = ~clk;

  collision_vector_gen #(.STAGES(STAGES), .COLS(COLS)) dut (
    .clk(clk), .rst(rst), .start(start), .table_rows(table_rows),
    .busy(busy), .done(done), .cvec(cvec), .max_lat(max_lat)
  );

  // {table (row2,row1,row0), expected cvec, expected max_lat}
  localparam int NV = 8;
  localparam logic [33:0] VECS [NV] = '{
    {24'h540AA1, 7'h5A, 3'd7},
    {24'h000000, 7'h00, 3'd0},
    {24'h800201, 7'h00, 3'd0},
    {24'h0000FF, 7'h7F, 3'd7},
    {24'h000003, 7'h01, 3'd1},
    {24'h810000, 7'h40, 3'd7},
    {24'h240611, 7'h0D, 3'd4},
    {24'h004900, 7'h24, 3'd6}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [TW-1:0] t);
    @(negedge clk);
    table_rows = t;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag, output int n);
    n = 0;
    for (int k = 1; k <= 20; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (done) begin
        n = k;
        break;
      end
    end
    check(n == COLS - 1, tag, n, COLS - 1);
  endtask

  task automatic run_one(input logic [TW-1:0] t, input logic [6:0] ev, input logic [2:0] em);
    int n;
    pulse_start(t);
    check(busy && cvec == 7'h0 && max_lat == 3'd0, "R5 start clears", {busy, cvec, max_lat}, {1'b1, 10'h0});
    wait_done("R4 done timing", n);
    check(cvec == ev, "R2 cvec", cvec, ev);
    check(max_lat == em, "R3 max_lat", max_lat, em);
    @(negedge clk);
    check(!done && !busy, "R4 done one cycle", {done, busy}, 0);
    check(cvec == ev && max_lat == em, "R8 result held", {cvec, max_lat}, {ev, em});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual %0d expected <5000 cycles", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    int n;
    rst = 1'b1;
    start = 1'b0;
    table_rows = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !done && cvec == 0 && max_lat == 0, "R1 reset state", {busy, done, cvec, max_lat}, 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++)
      run_one(VECS[v][33:10], VECS[v][9:3], VECS[v][2:0]);

    // R8: idle cycles keep the last result
    repeat (5) @(negedge clk);
    check(cvec == 7'h24 && max_lat == 3'd6, "R8 idle hold", {cvec, max_lat}, {7'h24, 3'd6});

    // R6: table change during run is ignored
    pulse_start(24'h000003);
    table_rows = 24'h0000FF;
    wait_done("R6 done timing", n);
    check(cvec == 7'h01 && max_lat == 3'd1, "R6 table captured", {cvec, max_lat}, {7'h01, 3'd1});

    // R7: restart while busy
    pulse_start(24'h0000FF);
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
    end
    check(busy && !done, "R7 still busy", {busy, done}, 2);
    pulse_start(24'h810000);
    check(cvec == 0 && max_lat == 0, "R7 restart clears", {cvec, max_lat}, 0);
    wait_done("R7 done after restart", n);
    check(cvec == 7'h40 && max_lat == 3'd7, "R7 new result", {cvec, max_lat}, {7'h40, 3'd7});

    // R1: reset during a run
    pulse_start(24'h540AA1);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(!busy && !done && cvec == 0 && max_lat == 0, "R1 reset mid-run", {busy, done, cvec, max_lat}, 0);
    repeat (10) @(negedge clk);
    check(!done && cvec == 0, "R1 no done after reset", {done, cvec}, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule